// File: doc/BRIEF.md
# Alert-Line Responder with Arbitrated Self-Identification

This block is the target-side half of a shared-interrupt scheme on a two-wire serial bus. A monitoring device latches fault flags from its alarm inputs into a status register. While any latched flag is set and monitoring is running, the block pulls a shared active-low alert line through an open-drain enable. The host reacts by issuing a one-byte read to a fixed broadcast address. Every device with a pending alert acknowledges that read and then shifts out its own 7-bit address. Because the data line is a wired-AND, the device with the numerically lower address survives the bitwise contest. Any device whose released bit is read back as low withdraws.

When the winner has shifted out all eight bits, it lets go of the alert line and stops monitoring. Monitoring resumes only when the host writes a clear mask to the alarm status register. At that point any flag still latched raises the alert again straight away. A losing device keeps its alert asserted and answers again on a later broadcast read. The SCL and SDA inputs go through a synchronizer, and START and STOP conditions are recovered from SDA edges that occur while SCL is high.

Top module: `alert_responder`

## Requirements
- R1: A read (R/W bit = 1) to the 7-bit address 0001100, with an alert pending, is acknowledged by pulling SDA low in the ninth clock. The device then sends 8 bits MSB first: its own 7-bit address followed by a 1.
- R2: The device never pulls SDA and sends no acknowledge in three cases: no alert is pending, the address differs from 0001100, or the R/W bit is 0. A pending alert is left unchanged by these transactions.
- R3: During the 8 answer bits, a bit that the device releases (a 1) but samples as 0 while SCL is high makes it stop driving for the rest of the transaction. Its alert remains asserted. As a result, the lower address among the simultaneous responders wins.
- R4: On the SCL falling edge that ends the eighth answer bit, the winner releases its alert and drops monitor_en low.
- R5: While monitor_en is low, alarm inputs are not latched and the alert output cannot become asserted.
- R6: A cycle with clr_we high clears the status bits set in clr_mask and raises monitor_en on the next cycle. If any status bit is still set, the alert reasserts one cycle after that. If no bit is left set, the alert stays released.
- R7: A STOP condition in the middle of an answer returns the responder to idle with the alert still asserted. A later broadcast read is answered normally.
- R8: After reset, the alert and SDA enables are low, monitor_en is high and every status bit is cleared.
- R9: While monitoring, an alarm input bit that is high at a clock edge is latched there. The alert asserts at the following edge.
- R10: SDA drive turns on only while SCL is low, and it is on only while the device's alert is asserted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| scl_in | input | 1 | Sensed level of the serial clock line |
| sda_in | input | 1 | Sensed level of the serial data line |
| sda_oe | output | 1 | When high, pulls the data line low |
| alert_oe | output | 1 | When high, pulls the shared active-low alert line low |
| monitor_en | output | 1 | High while alarm inputs are being latched |
| alarm_in | input | NUM_ALARMS | Fault flags from the threshold comparators |
| clr_we | input | 1 | Host write strobe to the alarm status register |
| clr_mask | input | NUM_ALARMS | Status bits to clear on that write |

## Verification
On every cycle, the checker enforces the interlock between alert and monitoring. The alert cannot rise while monitoring is suspended, monitoring stops only together with an alert release, and it resumes only after a clear write. The checker also requires that SDA drive starts only while SCL is low and only while an alert is pending. Other behaviours need two responders on one wired-AND bus driven by the bench's host: the bitwise arbitration outcome, the returned address byte, a STOP cutting an answer short, and reads that must go unanswered. For these, the bench's behavioural model of status, alert and monitoring is compared against both devices on every clock.

// File: rtl/alert_resp_pkg.sv
package alert_resp_pkg;
  localparam logic [6:0] ARA_ADDR = 7'b0001100;

  typedef enum logic [2:0] {
    LNK_IDLE,
    LNK_ADDR,
    LNK_ACK,
    LNK_SEND,
    LNK_HOLD
  } link_state_t;
endpackage

// File: rtl/ar_bus_sampler.sv
module ar_bus_sampler #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic scl_in,
  input  logic sda_in,
  output logic sda_s,
  output logic start_p,
  output logic stop_p,
  output logic rise_p,
  output logic fall_p
);
  logic [SYNC_STAGES-1:0] scl_sh, sda_sh;
  logic scl_now, scl_d, sda_d;

  generate
    if (SYNC_STAGES == 1) begin : g_one
      always_ff @(posedge clk) begin
        if (rst) begin
          scl_sh <= '1;
          sda_sh <= '1;
        end else begin
          scl_sh <= scl_in;
          sda_sh <= sda_in;
        end
      end
    end else begin : g_many
      always_ff @(posedge clk) begin
        if (rst) begin
          scl_sh <= '1;
          sda_sh <= '1;
        end else begin
          scl_sh <= {scl_sh[SYNC_STAGES-2:0], scl_in};
          sda_sh <= {sda_sh[SYNC_STAGES-2:0], sda_in};
        end
      end
    end
  endgenerate

  assign scl_now = scl_sh[SYNC_STAGES-1];
  assign sda_s   = sda_sh[SYNC_STAGES-1];

  always_ff @(posedge clk) begin
    if (rst) begin
      scl_d <= 1'b1;
      sda_d <= 1'b1;
    end else begin
      scl_d <= scl_now;
      sda_d <= sda_s;
    end
  end

  // SDA moving while SCL stays high marks bus framing
  assign start_p = scl_now & scl_d & sda_d & ~sda_s;
  assign stop_p  = scl_now & scl_d & ~sda_d & sda_s;
  assign rise_p  = scl_now & ~scl_d;
  assign fall_p  = ~scl_now & scl_d;
endmodule

// File: rtl/ar_alarm_ctrl.sv
module ar_alarm_ctrl #(
  parameter int NUM_ALARMS = 4
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic [NUM_ALARMS-1:0] alarm_in,
  input  logic                  clr_we,
  input  logic [NUM_ALARMS-1:0] clr_mask,
  input  logic                  win_p,
  output logic                  irq,
  output logic                  mon_run
);
  logic [NUM_ALARMS-1:0] status;
  logic [NUM_ALARMS-1:0] kept;

  assign kept = clr_we ? (status & ~clr_mask) : status;

  always_ff @(posedge clk) begin
    if (rst) begin
      status  <= '0;
      mon_run <= 1'b1;
      irq     <= 1'b0;
    end else begin
      status <= kept | (mon_run ? alarm_in : '0);
      if (win_p) begin
        // identified: release alert and hold off monitoring
        irq     <= 1'b0;
        mon_run <= 1'b0;
      end else begin
        if (clr_we) mon_run <= 1'b1;
        if (mon_run && (|status)) irq <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/ar_link.sv
module ar_link
  import alert_resp_pkg::*;
#(
  parameter logic [6:0] OWN_ADDR = 7'h2A
) (
  input  logic clk,
  input  logic rst,
  input  logic sda_s,
  input  logic start_p,
  input  logic stop_p,
  input  logic rise_p,
  input  logic fall_p,
  input  logic irq,
  output logic sda_oe,
  output logic win_p
);
  localparam logic [7:0] MATCH_BYTE = {ARA_ADDR, 1'b1};
  localparam logic [7:0] TX_WORD    = {OWN_ADDR, 1'b1};

  link_state_t state;
  logic [3:0]  cnt;
  logic [7:0]  rx_sh;
  logic [7:0]  tx_sh;

  assign win_p = (state == LNK_SEND) && fall_p && (cnt == 4'd7) && !start_p && !stop_p;

  always_ff @(posedge clk) begin
    if (rst) begin
      state  <= LNK_IDLE;
      cnt    <= '0;
      rx_sh  <= '0;
      tx_sh  <= '0;
      sda_oe <= 1'b0;
    end else if (start_p) begin
      state  <= LNK_ADDR;
      cnt    <= '0;
      sda_oe <= 1'b0;
    end else if (stop_p) begin
      state  <= LNK_IDLE;
      sda_oe <= 1'b0;
    end else begin
      unique case (state)
        LNK_ADDR: begin
          if (rise_p && cnt < 4'd8) begin
            rx_sh <= {rx_sh[6:0], sda_s};
            cnt   <= cnt + 4'd1;
          end
          if (fall_p && cnt == 4'd8) begin
            if (rx_sh == MATCH_BYTE && irq) begin
              state  <= LNK_ACK;
              sda_oe <= 1'b1;
            end else begin
              state <= LNK_HOLD;
            end
          end
        end
        LNK_ACK: begin
          if (fall_p) begin
            state  <= LNK_SEND;
            tx_sh  <= TX_WORD;
            sda_oe <= ~TX_WORD[7];
            cnt    <= '0;
          end
        end
        LNK_SEND: begin
          if (rise_p && tx_sh[7] && !sda_s) begin
            // released a one, line reads zero: another responder wins
            state  <= LNK_HOLD;
            sda_oe <= 1'b0;
          end else if (fall_p) begin
            if (cnt == 4'd7) begin
              state  <= LNK_HOLD;
              sda_oe <= 1'b0;
            end else begin
              tx_sh  <= {tx_sh[6:0], 1'b0};
              sda_oe <= ~tx_sh[6];
              cnt    <= cnt + 4'd1;
            end
          end
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/alert_responder.sv
module alert_responder #(
  parameter logic [6:0] OWN_ADDR    = 7'h2A,
  parameter int         NUM_ALARMS  = 4,
  parameter int         SYNC_STAGES = 2
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  scl_in,
  input  logic                  sda_in,
  output logic                  sda_oe,
  output logic                  alert_oe,
  output logic                  monitor_en,
  input  logic [NUM_ALARMS-1:0] alarm_in,
  input  logic                  clr_we,
  input  logic [NUM_ALARMS-1:0] clr_mask
);
  logic sda_s, start_p, stop_p, rise_p, fall_p;
  logic win_p, irq, mon_run;

  ar_bus_sampler #(.SYNC_STAGES(SYNC_STAGES)) u_sampler (
    .clk(clk), .rst(rst), .scl_in(scl_in), .sda_in(sda_in),
    .sda_s(sda_s), .start_p(start_p), .stop_p(stop_p),
    .rise_p(rise_p), .fall_p(fall_p)
  );

  ar_link #(.OWN_ADDR(OWN_ADDR)) u_link (
    .clk(clk), .rst(rst), .sda_s(sda_s), .start_p(start_p),
    .stop_p(stop_p), .rise_p(rise_p), .fall_p(fall_p), .irq(irq),
    .sda_oe(sda_oe), .win_p(win_p)
  );

  ar_alarm_ctrl #(.NUM_ALARMS(NUM_ALARMS)) u_alarm (
    .clk(clk), .rst(rst), .alarm_in(alarm_in), .clr_we(clr_we),
    .clr_mask(clr_mask), .win_p(win_p), .irq(irq), .mon_run(mon_run)
  );

  assign alert_oe   = irq;
  assign monitor_en = mon_run;
endmodule

// File: rtl/alert_responder_chk.sv
module alert_responder_chk (
  input logic clk,
  input logic rst,
  input logic scl_in,
  input logic clr_we,
  input logic sda_oe,
  input logic alert_oe,
  input logic monitor_en
);
  assert_reset_state_R8: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!alert_oe && !sda_oe && monitor_en));

  assert_suspended_no_alert_R5: assert property (@(posedge clk) disable iff (rst)
    (!monitor_en && !alert_oe) |=> !alert_oe);

  assert_suspend_with_release_R4: assert property (@(posedge clk) disable iff (rst)
    $fell(monitor_en) |-> $fell(alert_oe));

  assert_resume_after_clear_R6: assert property (@(posedge clk) disable iff (rst)
    $rose(monitor_en) |-> $past(clr_we));

  assert_drive_needs_alert_R10: assert property (@(posedge clk) disable iff (rst)
    sda_oe |-> alert_oe);

  assert_drive_starts_scl_low_R10: assert property (@(posedge clk) disable iff (rst)
    $rose(sda_oe) |-> !scl_in);
endmodule

bind alert_responder alert_responder_chk chk_i (
  .clk(clk), .rst(rst), .scl_in(scl_in), .clr_we(clr_we),
  .sda_oe(sda_oe), .alert_oe(alert_oe), .monitor_en(monitor_en)
);

// File: tb/alert_responder_tb_top.sv
module alert_responder_tb_top;
  localparam int HALF = 10;
  localparam logic [6:0] ADDR_A = 7'h2A;
  localparam logic [6:0] ADDR_B = 7'h33;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #10 clk = ~clk;

  logic host_scl = 1'b1, host_sda = 1'b1;
  logic [1:0] oe_v, alert_v, mon_v;
  logic [3:0] alarm_v [2];
  logic [1:0] clr_we_v;
  logic [3:0] clr_mask_v [2];
  wire sda_bus = host_sda & ~oe_v[0] & ~oe_v[1];

  int checks = 0, fails = 0;
  bit finished = 0;

  alert_responder #(.OWN_ADDR(ADDR_A)) dut_i (
    .clk(clk), .rst(rst), .scl_in(host_scl), .sda_in(sda_bus),
    .sda_oe(oe_v[0]), .alert_oe(alert_v[0]), .monitor_en(mon_v[0]),
    .alarm_in(alarm_v[0]), .clr_we(clr_we_v[0]), .clr_mask(clr_mask_v[0]));

  alert_responder #(.OWN_ADDR(ADDR_B)) dut_b (
    .clk(clk), .rst(rst), .scl_in(host_scl), .sda_in(sda_bus),
    .sda_oe(oe_v[1]), .alert_oe(alert_v[1]), .monitor_en(mon_v[1]),
    .alarm_in(alarm_v[1]), .clr_we(clr_we_v[1]), .clr_mask(clr_mask_v[1]));

  // behavioural reference: latched status, alert and monitoring per device
  int m_status [2];
  bit m_irq [2], m_mon [2], win_req [2], p_irq [2], p_mon [2];
  int stab [2];

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  always @(posedge clk) begin
    for (int d = 0; d < 2; d++) begin
      if (rst) begin
        m_status[d] = 0; m_irq[d] = 0; m_mon[d] = 1; win_req[d] = 0;
      end else begin
        int old_st; bit old_mon;
        old_st = m_status[d]; old_mon = m_mon[d];
        if (clr_we_v[d]) m_status[d] = m_status[d] & ~int'(clr_mask_v[d]);
        if (old_mon) m_status[d] = m_status[d] | int'(alarm_v[d]);
        if (win_req[d]) begin
          m_irq[d] = 0; m_mon[d] = 0; win_req[d] = 0;
        end else begin
          if (clr_we_v[d]) m_mon[d] = 1;
          if (old_mon && old_st != 0) m_irq[d] = 1;
        end
      end
    end
  end

  // per-clock comparison once the model has been steady for a few cycles (R4 R5 R6 R9)
  always @(negedge clk) begin
    for (int d = 0; d < 2; d++) begin
      if (rst || m_irq[d] != p_irq[d] || m_mon[d] != p_mon[d]) stab[d] = 0;
      else stab[d]++;
      p_irq[d] = m_irq[d]; p_mon[d] = m_mon[d];
      if (!rst && !finished && stab[d] >= 6) begin
        chk(alert_v[d] == m_irq[d], "R9 alert vs model", alert_v[d], m_irq[d]);
        chk(mon_v[d] == m_mon[d], "R6 monitor_en vs model", mon_v[d], m_mon[d]);
      end
    end
  end

  task automatic hclk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_start();
    host_sda = 1; host_scl = 1; hclk(HALF);
    host_sda = 0; hclk(HALF);
    host_scl = 0; hclk(2);
  endtask

  task automatic bus_stop();
    host_sda = 0; hclk(HALF);
    host_scl = 1; hclk(HALF);
    host_sda = 1; hclk(HALF);
  endtask

  task automatic bit_out(input logic b);
    host_sda = b; hclk(HALF);
    host_scl = 1; hclk(HALF);
    host_scl = 0;
  endtask

  task automatic bit_in(output logic b);
    host_sda = 1; hclk(HALF);
    host_scl = 1; hclk(HALF / 2);
    b = sda_bus; hclk(HALF / 2);
    host_scl = 0;
  endtask

  task automatic send_addr(input logic [6:0] a, input logic rw, output logic ack);
    logic [7:0] by;
    by = {a, rw};
    for (int i = 7; i >= 0; i--) bit_out(by[i]);
    bit_in(ack);
  endtask

  // broadcast read; the model winner is the lowest pending address
  task automatic ara_read(output logic ack, output logic [7:0] data);
    int w;
    w = -1;
    if (m_irq[0]) w = 0;
    if (m_irq[1] && (w < 0 || ADDR_B < ADDR_A)) w = 1;
    bus_start();
    send_addr(7'b0001100, 1'b1, ack);
    for (int i = 7; i >= 0; i--) begin
      logic b;
      bit_in(b);
      data[i] = b;
    end
    if (w >= 0) win_req[w] = 1;
    bit_out(1'b1);
    bus_stop();
    hclk(8);
  endtask

  function automatic logic [7:0] exp_byte();
    if (m_irq[0] && (!m_irq[1] || ADDR_A < ADDR_B)) return {ADDR_A, 1'b1};
    if (m_irq[1]) return {ADDR_B, 1'b1};
    return 8'hFF;
  endfunction

  task automatic do_clear(input int d, input logic [3:0] mask);
    clr_mask_v[d] = mask; clr_we_v[d] = 1; hclk(1);
    clr_we_v[d] = 0; clr_mask_v[d] = 0;
  endtask

  task automatic pulse_alarm(input int d, input logic [3:0] v);
    alarm_v[d] = v; hclk(3); alarm_v[d] = 0; hclk(10);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=%0h expected=%0h", 1, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    logic ack;
    logic [7:0] data, ex;
    alarm_v[0] = 0; alarm_v[1] = 0; clr_we_v = 0;
    clr_mask_v[0] = 0; clr_mask_v[1] = 0;
    hclk(5); rst = 0; hclk(2);

    // R8 reset state
    chk(alert_v == 2'b00, "R8 alerts after reset", alert_v, 0);
    chk(oe_v == 2'b00, "R8 sda drive after reset", oe_v, 0);
    chk(mon_v == 2'b11, "R8 monitor_en after reset", mon_v, 3);

    // R9 latch then R1/R4 single responder
    alarm_v[1] = 4'b0011; hclk(3);
    chk(alert_v[1] == 1, "R9 alert after alarm", alert_v[1], 1);
    alarm_v[1] = 0; hclk(10);
    ex = exp_byte();
    ara_read(ack, data);
    chk(ack == 0, "R1 ack on broadcast read", ack, 0);
    chk(data == ex && data == 8'h67, "R1 returned address byte", data, 8'h67);
    chk(alert_v[1] == 0, "R4 alert released after win", alert_v[1], 0);
    chk(mon_v[1] == 0, "R4 monitoring suspended", mon_v[1], 0);
    chk(alert_v[0] == 0, "R2 idle device stays quiet", alert_v[0], 0);

    // R5 suspended: new alarm ignored
    alarm_v[1] = 4'b0100; hclk(30); alarm_v[1] = 0; hclk(4);
    chk(alert_v[1] == 0, "R5 no alert while suspended", alert_v[1], 0);

    // R6 partial clear reasserts immediately
    do_clear(1, 4'b0001);
    chk(mon_v[1] == 1, "R6 monitoring resumed", mon_v[1], 1);
    hclk(1);
    chk(alert_v[1] == 1, "R6 remaining bit reasserts", alert_v[1], 1);
    ara_read(ack, data);
    chk(data == 8'h67, "R1 second answer", data, 8'h67);
    do_clear(1, 4'b1111); hclk(20);
    chk(alert_v[1] == 0, "R6 full clear leaves alert off", alert_v[1], 0);
    chk(mon_v[1] == 1, "R6 resumed after full clear", mon_v[1], 1);

    // R3 arbitration between two pending responders
    pulse_alarm(1, 4'b0100);
    pulse_alarm(0, 4'b0001);
    ex = exp_byte();
    ara_read(ack, data);
    chk(data == ex && data == 8'h55, "R3 lower address wins", data, 8'h55);
    chk(alert_v[0] == 0, "R3 winner released", alert_v[0], 0);
    hclk(40);
    chk(alert_v[1] == 1, "R3 loser keeps alert", alert_v[1], 1);
    ara_read(ack, data);
    chk(data == 8'h67, "R3 loser answers later", data, 8'h67);
    chk(alert_v[1] == 0, "R4 loser released when served", alert_v[1], 0);
    do_clear(0, 4'b1111); do_clear(1, 4'b1111); hclk(10);

    // R7 STOP in mid-answer
    pulse_alarm(0, 4'b1000);
    bus_start();
    send_addr(7'b0001100, 1'b1, ack);
    chk(ack == 0, "R7 ack before abort", ack, 0);
    for (int i = 0; i < 3; i++) begin
      logic b;
      bit_in(b);
    end
    bus_stop(); hclk(10);
    chk(alert_v[0] == 1, "R7 alert kept after STOP", alert_v[0], 1);
    chk(mon_v[0] == 1, "R7 still monitoring", mon_v[0], 1);
    ara_read(ack, data);
    chk(data == 8'h55, "R7 later read answered", data, 8'h55);
    do_clear(0, 4'b1111); hclk(10);

    // R2 no pending, wrong address, write direction
    ara_read(ack, data);
    chk(ack == 1, "R2 no ack without pending", ack, 1);
    chk(data == 8'hFF, "R2 bus idle data", data, 8'hFF);
    pulse_alarm(0, 4'b0010);
    bus_start(); send_addr(7'h50, 1'b1, ack); bus_stop(); hclk(8);
    chk(ack == 1, "R2 other address not acked", ack, 1);
    bus_start(); send_addr(7'b0001100, 1'b0, ack); bus_stop(); hclk(8);
    chk(ack == 1, "R2 write direction not acked", ack, 1);
    chk(alert_v[0] == 1, "R2 alert unchanged", alert_v[0], 1);
    ara_read(ack, data);
    chk(data == 8'h55, "R1 answer after ignored traffic", data, 8'h55);

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule